// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block watches a decoded line bit stream and declares digital loss of signal when the line goes quiet for too long. Each accepted bit feeds a run counter of consecutive zeros. When the run reaches the set threshold, the status flag `los` goes high. The flag depends only on bit values and never on analog amplitude.

While the flag is high, the detector measures pulse density over fixed windows of accepted bits. A window that holds enough ones clears the flag. A window that falls short is discarded, and a fresh window starts with the next accepted bit. The flag is not sticky: it always shows the current condition.

Bits arrive on a valid/ready stream. A bit is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. The block never applies back-pressure, so `in_ready` is always high. Cycles with `in_valid` low carry no bit and change nothing. The thresholds are parameters: run length 175, window length 175 and minimum ones 58. The run length and window length must lie in the range 100 to 250, and elaboration stops if they do not.

Top module: `dlos_detector`

## Requirements
- R1: After reset, `los` is 0 and both the zero-run count and the density window are empty.
- R2: While `los` is 0, `los` goes to 1 in the cycle after the RUN_LEN-th consecutive accepted zero (`in_bit` = 0). The default RUN_LEN is 175.
- R3: While `los` is 0, an accepted one (`in_bit` = 1) restarts the zero run. For example, 174 zeros, then a one, then 174 zeros leaves `los` at 0.
- R4: A cycle with `in_valid` low neither counts as a bit nor breaks a run. `los` changes only in the cycle after an accepted bit.
- R5: While `los` is 1, accepted bits are grouped into windows of WIN_LEN bits (default 175). The first window starts with the first bit accepted after the flag rises. If a window holds at least MIN_ONES ones (default 58), `los` falls to 0 in the cycle after the window's last bit.
- R6: A window holding fewer than MIN_ONES ones leaves `los` at 1. The next window starts with a count of zero, so no ones carry over from the failed window.
- R7: `in_ready` is 1 in every cycle, so the upstream source is never stalled.
- R8: Zeros accepted while `los` is 1 do not count toward a later declaration. After the flag clears, a new declaration needs RUN_LEN fresh consecutive zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream offers a bit this cycle |
| in_ready | output | 1 | Always 1; the detector accepts every offered bit |
| in_bit | input | 1 | Decoded line bit; 1 is a pulse, 0 is no pulse |
| los | output | 1 | Digital loss-of-signal status; 1 while the condition holds |

## Verification
Two events can land on the same bit: the last bit of a density window and the one that brings the window's count up to MIN_ONES. To provoke this, the bench sends a window of 57 ones, then 117 zeros, and ends it with a single one. The flag must fall in the cycle right after that final one, not one window later. A second window with 57 ones in total must instead keep the flag high and restart from zero. A scoreboard model built from the requirements predicts the flag after every accepted bit. The bench also checks that idle cycles in the middle of a run leave the flag untouched.

// File: rtl/dlos_pkg.sv
package dlos_pkg;
  typedef enum logic {
    ST_TRACK = 1'b0,
    ST_LOST  = 1'b1
  } dlos_state_e;

  function automatic bit in_range(input int unsigned v, input int unsigned lo,
                                  input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/dlos_zero_run.sv
module dlos_zero_run #(
  parameter int unsigned RUN_LEN = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_i,
  input  logic clr,
  output logic hit
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign hit = en && !bit_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (en) begin
      if (bit_i || hit) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the run count never passes the last position before declaration
  p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R3: an accepted one empties the run
  p_one_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bit_i) |=> (cnt_q == '0));
endmodule

// File: rtl/dlos_density_window.sv
module dlos_density_window #(
  parameter int unsigned WIN_LEN  = 175,
  parameter int unsigned MIN_ONES = 58
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_i,
  input  logic clr,
  output logic pass
);
  localparam int unsigned WW = $clog2(WIN_LEN + 1);
  localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);
  localparam logic [WW-1:0] NEED = WW'(MIN_ONES);

  logic [WW-1:0] pos_q;
  logic [WW-1:0] ones_q;
  logic [WW-1:0] ones_nx;
  logic          at_end;

  assign ones_nx = ones_q + WW'(bit_i);
  assign at_end  = en && (pos_q == LAST);
  assign pass    = at_end && (ones_nx >= NEED);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pos_q  <= '0;
      ones_q <= '0;
    end else if (en) begin
      if (at_end) begin
        pos_q  <= '0;
        ones_q <= '0;
      end else begin
        pos_q  <= pos_q + 1'b1;
        ones_q <= ones_nx;
      end
    end
  end

  // R6: a window can never hold more ones than bits
  p_ones_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= pos_q);

  // R6: a finished window leaves both counts empty for the next one
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !clr) |=> (pos_q == '0 && ones_q == '0));
endmodule

// File: rtl/dlos_fsm.sv
module dlos_fsm
  import dlos_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_hit,
  input  logic win_pass,
  output logic lost
);
  dlos_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_TRACK: if (run_hit)  st_d = ST_LOST;
      ST_LOST:  if (win_pass) st_d = ST_TRACK;
      default:  st_d = ST_TRACK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_TRACK;
    else        st_q <= st_d;
  end

  assign lost = (st_q == ST_LOST);

  // R2: a completed zero run raises the flag on the next cycle
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lost && run_hit) |=> lost);

  // R5: a passing window drops the flag on the next cycle
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && win_pass) |=> !lost);
endmodule

// File: rtl/dlos_detector.sv
module dlos_detector #(
  parameter int unsigned RUN_LEN  = 175,
  parameter int unsigned WIN_LEN  = 175,
  parameter int unsigned MIN_ONES = 58
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic los
);
  localparam bit PARAMS_OK = dlos_pkg::in_range(RUN_LEN, 100, 250) &&
                             dlos_pkg::in_range(WIN_LEN, 100, 250) &&
                             dlos_pkg::in_range(MIN_ONES, 1, WIN_LEN);

  generate
    if (!PARAMS_OK) begin : g_param_check
      $error("dlos_detector: threshold parameter outside allowed range");
    end
  endgenerate

  logic take;
  logic run_hit;
  logic win_pass;
  logic lost;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  dlos_zero_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (take && !lost),
    .bit_i (in_bit),
    .clr   (lost),
    .hit   (run_hit)
  );

  dlos_density_window #(.WIN_LEN(WIN_LEN), .MIN_ONES(MIN_ONES)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (take && lost),
    .bit_i (in_bit),
    .clr   (!lost),
    .pass  (win_pass)
  );

  dlos_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_hit  (run_hit),
    .win_pass (win_pass),
    .lost     (lost)
  );

  assign los = lost;

  // R7: the stream is never back-pressured
  p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  // R4: without an accepted bit the flag holds
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(los));
endmodule

// File: tb/dlos_detector_tb_top.sv
module dlos_detector_tb_top;
  localparam int RUN = 175;
  localparam int WIN = 175;
  localparam int NEED = 58;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready;
  logic los;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // scoreboard model state
  bit m_los = 1'b0;
  int m_run = 0;
  int m_pos = 0;
  int m_ones = 0;
  string cur_req = "R1";

  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  dlos_detector dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .los(los)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit b);
    if (!m_los) begin
      if (b) m_run = 0;
      else   m_run++;
      if (m_run == RUN) begin
        m_los = 1'b1; m_run = 0; m_pos = 0; m_ones = 0;
      end
    end else begin
      m_pos++;
      m_ones += int'(b);
      if (m_pos == WIN) begin
        if (m_ones >= NEED) m_los = 1'b0;
        m_pos = 0; m_ones = 0;
      end
    end
  endtask

  task automatic send(input bit b);
    @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    model_step(b);
    exp_q.push_back(m_los);
    tag_q.push_back(cur_req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_bit   = 1'b1;
    end
  endtask

  task automatic send_n(input bit b, input int n);
    for (int i = 0; i < n; i++) send(b);
  endtask

  task automatic drain;
    idle(2);
  endtask

  // monitor: compare after every accepted bit, hold check otherwise
  initial begin
    bit took;
    bit prev;
    prev = 1'b0;
    forever begin
      @(posedge clk);
      took = in_valid && rst_n;
      @(negedge clk);
      if (rst_n) begin
        if (took && exp_q.size() > 0) begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(los == e, t, int'(los), int'(e));
        end else if (!took) begin
          check(los == prev, "R4", int'(los), int'(prev));
        end
        prev = los;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h1234_5678;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(los == 1'b0, "R1", int'(los), 0);
    check(in_ready == 1'b1, "R7", int'(in_ready), 1);

    // R3: a one restarts the run
    cur_req = "R3";
    send_n(1'b0, RUN - 1);
    send(1'b1);
    send_n(1'b0, RUN - 1);
    send(1'b1);
    drain();

    // R4 and R2: gaps inside a run, declaration on the RUN-th zero
    cur_req = "R4";
    send_n(1'b0, 100);
    idle(5);
    send_n(1'b0, RUN - 101);
    cur_req = "R2";
    send(1'b0);
    drain();
    check(los == 1'b1, "R2", int'(los), 1);
    check(in_ready == 1'b1, "R7", int'(in_ready), 1);

    // R6: a short window keeps the flag and restarts from zero
    cur_req = "R6";
    send_n(1'b1, NEED - 1);
    send_n(1'b0, WIN - NEED + 1);
    // R5: enough ones clears; trailing zeros must not carry (R8)
    cur_req = "R5";
    send_n(1'b1, NEED);
    send_n(1'b0, WIN - NEED);
    drain();
    check(los == 1'b0, "R5", int'(los), 0);

    cur_req = "R8";
    send_n(1'b0, RUN - 1);
    drain();
    check(los == 1'b0, "R8", int'(los), 0);
    send(1'b0);
    drain();
    check(los == 1'b1, "R8", int'(los), 1);

    // same-bit case: window end coincides with the NEED-th one
    cur_req = "R5";
    send_n(1'b1, NEED - 1);
    send_n(1'b0, WIN - NEED);
    send(1'b1);
    drain();
    check(los == 1'b0, "R5", int'(los), 0);

    // mixed stream with gaps and shifting density
    cur_req = "R6";
    for (int k = 0; k < 3000; k++) begin
      int dens;
      seed = seed * 32'd1103515245 + 32'd12345;
      dens = (k / 500) % 2 == 0 ? 3 : 40;
      if (seed[27:24] == 4'd0) idle(1);
      send(((seed >> 8) % 100) < dens);
    end
    drain();

    idle(3);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule